// File: doc/BRIEF.md
# Eight-Bit ALU with Status Flags

This block is the arithmetic and logic datapath of a small RISC microcontroller core. It takes two operand bytes (the caller chooses whether the second one is a register value or an immediate) and an operation code. It returns the result byte at once, without a clock. Alongside the result it returns the value the status register would take if the operation's flags were committed. The status register is held inside the block, and its carry bit is the carry input used by the carry-consuming operations.

Each operation writes only the flags it defines. All other flags keep their current value. The status register loads the proposed value on a rising clock edge, and only while the flag-write strobe is high. A synchronous active-high reset clears it.

The layout of the status byte, from bit 7 down to bit 0, is I, T, H, S, V, N, Z, C. A decoder outside the block depends on this order, so it is kept fixed.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising edge, `sreg` becomes 0x00 on that edge, even if `flag_we` is also high.
- R2: At a rising edge with `rst` low, `sreg` takes `sreg_next` when `flag_we` is 1 and keeps its value when `flag_we` is 0. The bits of `sreg` are I=7, T=6, H=5, S=4, V=3, N=2, Z=1, C=0.
- R3: Add (op 0) gives `res = opa + opb`. Add-with-carry (op 1) also adds `sreg[0]`. Both write all of C, Z, N, V, S and H: C is the carry out of bit 7, H is the carry out of bit 3, and V is signed overflow.
- R4: Subtract (op 2) gives `res = opa - opb`. Subtract-with-carry (op 3) also subtracts `sreg[0]`. C is set when the unsigned `opa` is smaller than `opb` plus the carry-in. H is the same test on bits 3..0. V is signed overflow. Z, N and S are also written.
- R5: AND (op 4), OR (op 5) and XOR (op 6) write Z, N and S, clear V, and leave C, H, I and T unchanged.
- R6: Increment (op 9) and decrement (op 10) give `opa + 1` and `opa - 1`. V is set when the result is 0x80 (increment) or 0x7F (decrement). Z, N and S are written. C and H are unchanged.
- R7: One's complement (op 7) gives `res = 0xFF - opa`, sets C to 1, clears V, and writes Z, N and S. H is unchanged.
- R8: Negate (op 8) gives `res = 0x00 - opa`. It sets C when `opa` is nonzero, H when `opa[3:0]` is nonzero, and V when `opa` is 0x80. Z, N and S are written.
- R9: The shift and rotate operations are shift left (op 11), shift right (op 12), rotate left through C (op 13), rotate right through C (op 14) and arithmetic shift right (op 15). The two plain shifts fill with zero. The rotates fill the vacated bit from the old C. The arithmetic shift keeps bit 7. In every case C takes the bit shifted out, V = N xor C, and Z, N and S are written.
- R10: Nibble swap (op 16) returns `{opa[3:0], opa[7:4]}`, and `sreg_next` equals `sreg`.
- R11: Flag set (op 17) and flag clear (op 18) write 1 or 0 into the status bit whose index is `opb[2:0]`. No other bit changes, and `res` equals `opa`.
- R12: For every operation that writes N, Z is 1 exactly when `res` is 0x00, N equals `res[7]`, and S equals N xor the new V. I and T change only through R11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the status register |
| op | input | 5 | Operation code (see requirements) |
| opa | input | 8 | First operand byte |
| opb | input | 8 | Second operand byte, register or immediate; bits 2..0 give the flag index for ops 17/18 |
| flag_we | input | 1 | Commit `sreg_next` into the status register on the next edge |
| res | output | 8 | Combinational result byte |
| sreg_next | output | 8 | Proposed status register value |
| sreg | output | 8 | Registered status register |

## Verification
Two functions can meet in a single cycle.

- **Reset and flag write.** The bench holds `rst` high while presenting a flag-set with `flag_we` high, and requires `sreg` to read 0x00 afterwards.
- **Carry read and carry write.** The carry-reading operations (add/subtract with carry, rotates) take the C that the previous cycle's committed operation wrote, while the same edge writes a new C. The bench runs back-to-back random operations with the strobe mostly high and models the carry from its own copy of the register, so a stale or early carry shows up as a miscompare in `res` or `sreg_next`.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OPW = 5;
  localparam int SRW = 8;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_AND  = 5'd4,
    OP_OR   = 5'd5,
    OP_XOR  = 5'd6,
    OP_COM  = 5'd7,
    OP_NEG  = 5'd8,
    OP_INC  = 5'd9,
    OP_DEC  = 5'd10,
    OP_LSL  = 5'd11,
    OP_LSR  = 5'd12,
    OP_ROL  = 5'd13,
    OP_ROR  = 5'd14,
    OP_ASR  = 5'd15,
    OP_SWAP = 5'd16,
    OP_BSET = 5'd17,
    OP_BCLR = 5'd18
  } alu_op_e;

  // Flags written by each operation (flag set/clear handled apart)
  localparam logic [SRW-1:0] MASK_ARITH = 8'b0011_1111;
  localparam logic [SRW-1:0] MASK_LOGIC = 8'b0001_1110;
  localparam logic [SRW-1:0] MASK_SHIFT = 8'b0001_1111;

  function automatic logic [SRW-1:0] flag_mask(input alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: flag_mask = MASK_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:  flag_mask = MASK_LOGIC;
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR,
      OP_ASR:                                 flag_mask = MASK_SHIFT;
      default:                                flag_mask = '0;
    endcase
  endfunction

  function automatic logic uses_adder(input alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_INC, OP_DEC: uses_adder = 1'b1;
      default: uses_adder = 1'b0;
    endcase
  endfunction

  function automatic logic uses_bitops(input alu_op_e op);
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR,
      OP_ASR, OP_SWAP: uses_bitops = 1'b1;
      default: uses_bitops = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          h_out,
  output logic          v_out
);
  localparam int HB = DW / 2;

  logic [DW-1:0] b_x;
  logic          c_x;
  logic [DW:0]   full;
  logic [HB:0]   half;

  // Subtraction as a + ~b + ~cin; borrow is the inverted carry
  always_comb begin
    b_x  = sub ? ~b : b;
    c_x  = sub ? ~cin : cin;
    full = {1'b0, a} + {1'b0, b_x} + {{DW{1'b0}}, c_x};
    half = {1'b0, a[HB-1:0]} + {1'b0, b_x[HB-1:0]} + {{HB{1'b0}}, c_x};
    sum   = full[DW-1:0];
    c_out = full[DW] ^ sub;
    h_out = half[HB] ^ sub;
    v_out = (a[DW-1] == b_x[DW-1]) && (full[DW-1] != a[DW-1]);
  end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] r,
  output logic          c_out
);
  localparam int HB = DW / 2;

  always_comb begin
    r     = a;
    c_out = 1'b0;
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM: begin
        r     = ~a;
        c_out = 1'b1;
      end
      OP_LSL: begin
        r     = {a[DW-2:0], 1'b0};
        c_out = a[DW-1];
      end
      OP_LSR: begin
        r     = {1'b0, a[DW-1:1]};
        c_out = a[0];
      end
      OP_ROL: begin
        r     = {a[DW-2:0], cin};
        c_out = a[DW-1];
      end
      OP_ROR: begin
        r     = {cin, a[DW-1:1]};
        c_out = a[0];
      end
      OP_ASR: begin
        r     = {a[DW-1], a[DW-1:1]};
        c_out = a[0];
      end
      OP_SWAP: r = {a[HB-1:0], a[DW-1:HB]};
      default: r = a;
    endcase
  end

endmodule

// File: rtl/alu8_flagmerge.sv
module alu8_flagmerge
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e        op,
  input  logic [SRW-1:0] cur,
  input  logic [DW-1:0]  res,
  input  logic           add_c,
  input  logic           add_h,
  input  logic           add_v,
  input  logic           bit_c,
  input  logic [2:0]     idx,
  output logic [SRW-1:0] nxt
);
  logic [SRW-1:0] mask;
  logic [SRW-1:0] fv;
  logic           v_new;
  logic           c_new;
  logic           n_new;

  always_comb begin
    n_new = res[DW-1];
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_COM:                 v_new = 1'b0;
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR:        v_new = n_new ^ bit_c;
      default:                                       v_new = add_v;
    endcase
    c_new = uses_adder(op) ? add_c : bit_c;

    fv         = cur;
    fv[FLG_H]  = add_h;
    fv[FLG_S]  = n_new ^ v_new;
    fv[FLG_V]  = v_new;
    fv[FLG_N]  = n_new;
    fv[FLG_Z]  = (res == '0);
    fv[FLG_C]  = c_new;
    mask       = flag_mask(op);

    if (op == OP_BSET || op == OP_BCLR) begin
      mask = '0;
      mask[idx] = 1'b1;
      fv   = {SRW{op == OP_BSET}};
    end

    nxt = (cur & ~mask) | (fv & mask);
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [4:0]     op,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  input  logic           flag_we,
  output logic [DW-1:0]  res,
  output logic [SRW-1:0] sreg_next,
  output logic [SRW-1:0] sreg
);
  alu_op_e       op_e;
  logic [DW-1:0] add_a;
  logic [DW-1:0] add_b;
  logic          add_ci;
  logic          add_sub;
  logic [DW-1:0] add_sum;
  logic          add_c;
  logic          add_h;
  logic          add_v;
  logic [DW-1:0] bit_r;
  logic          bit_c;
  logic          c_cur;

  assign op_e  = alu_op_e'(op);
  assign c_cur = sreg[FLG_C];

  // Route operands to the single shared adder
  always_comb begin
    add_a   = opa;
    add_b   = opb;
    add_ci  = 1'b0;
    add_sub = 1'b0;
    case (op_e)
      OP_ADC: add_ci = c_cur;
      OP_SUB: add_sub = 1'b1;
      OP_SBC: begin
        add_sub = 1'b1;
        add_ci  = c_cur;
      end
      OP_NEG: begin
        add_a   = '0;
        add_b   = opa;
        add_sub = 1'b1;
      end
      OP_INC: begin
        add_b  = '0;
        add_ci = 1'b1;
      end
      OP_DEC: begin
        add_b   = '0;
        add_ci  = 1'b1;
        add_sub = 1'b1;
      end
      default: ;
    endcase
  end

  alu8_addsub #(.DW(DW)) u_add (
    .a     (add_a),
    .b     (add_b),
    .cin   (add_ci),
    .sub   (add_sub),
    .sum   (add_sum),
    .c_out (add_c),
    .h_out (add_h),
    .v_out (add_v)
  );

  alu8_bitops #(.DW(DW)) u_bit (
    .op    (op_e),
    .a     (opa),
    .b     (opb),
    .cin   (c_cur),
    .r     (bit_r),
    .c_out (bit_c)
  );

  always_comb begin
    if (uses_adder(op_e))       res = add_sum;
    else if (uses_bitops(op_e)) res = bit_r;
    else                        res = opa;
  end

  alu8_flagmerge #(.DW(DW)) u_flg (
    .op    (op_e),
    .cur   (sreg),
    .res   (res),
    .add_c (add_c),
    .add_h (add_h),
    .add_v (add_v),
    .bit_c (bit_c),
    .idx   (opb[2:0]),
    .nxt   (sreg_next)
  );

  always_ff @(posedge clk) begin
    if (rst)          sreg <= '0;
    else if (flag_we) sreg <= sreg_next;
  end

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic           clk,
  input logic           rst,
  input logic [4:0]     op,
  input logic           flag_we,
  input logic [SRW-1:0] sreg_next,
  input logic [SRW-1:0] sreg
);
  logic writes_n;
  assign writes_n = (flag_mask(alu_op_e'(op)) != '0);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (sreg == '0));

  // R2
  flag_load_chk: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> (sreg == $past(sreg_next)));

  // R2
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(sreg));

  // R5
  logic_keeps_c_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_AND || op == OP_OR || op == OP_XOR) |->
      (sreg_next[FLG_C] == sreg[FLG_C] && sreg_next[FLG_H] == sreg[FLG_H]
       && !sreg_next[FLG_V]));

  // R7
  com_sets_c_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_COM) |-> (sreg_next[FLG_C] && !sreg_next[FLG_V]));

  // R10
  swap_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SWAP) |-> (sreg_next == sreg));

  // R11
  single_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BSET || op == OP_BCLR) |-> ($countones(sreg_next ^ sreg) <= 1));

  // R12
  sign_rule_chk: assert property (@(posedge clk) disable iff (rst)
    writes_n |-> (sreg_next[FLG_S] == (sreg_next[FLG_N] ^ sreg_next[FLG_V])));

  // R12
  it_kept_chk: assert property (@(posedge clk) disable iff (rst)
    writes_n |-> (sreg_next[FLG_I] == sreg[FLG_I] && sreg_next[FLG_T] == sreg[FLG_T]));

endmodule

bind alu8_core alu8_core_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .op        (op),
  .flag_we   (flag_we),
  .sreg_next (sreg_next),
  .sreg      (sreg)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] op;
  logic [7:0] opa, opb;
  logic       flag_we;
  logic [7:0] res, sreg_next, sreg;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;
  logic [7:0] m_sreg;

  always #2.5 clk = ~clk;

  alu8_core u0 (
    .clk(clk), .rst(rst), .op(op), .opa(opa), .opb(opb), .flag_we(flag_we),
    .res(res), .sreg_next(sreg_next), .sreg(sreg)
  );

  function automatic string req_of(input logic [4:0] o);
    case (o)
      0, 1:           return "R3";
      2, 3:           return "R4";
      4, 5, 6:        return "R5";
      7:              return "R7";
      8:              return "R8";
      9, 10:          return "R6";
      16:             return "R10";
      17, 18:         return "R11";
      default:        return "R9";
    endcase
  endfunction

  // Reference model: {result, next status}
  function automatic logic [15:0] model(input logic [4:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] s);
    logic [7:0] r, n;
    logic cc, hh, vv, wnz, wc, wh;
    int t, ci;
    n = s; r = a; cc = 0; hh = 0; vv = 0; wnz = 0; wc = 0; wh = 0;
    case (o)
      0, 1: begin
        ci = (o == 1) ? int'(s[0]) : 0;
        t = int'(a) + int'(b) + ci; r = t[7:0];
        cc = (t > 255); hh = (int'(a[3:0]) + int'(b[3:0]) + ci) > 15;
        vv = (a[7] == b[7]) && (r[7] != a[7]); wnz = 1; wc = 1; wh = 1;
      end
      2, 3: begin
        ci = (o == 3) ? int'(s[0]) : 0;
        t = int'(a) - int'(b) - ci; r = t[7:0];
        cc = int'(a) < int'(b) + ci; hh = int'(a[3:0]) < int'(b[3:0]) + ci;
        vv = (a[7] != b[7]) && (r[7] != a[7]); wnz = 1; wc = 1; wh = 1;
      end
      4: begin r = a & b; wnz = 1; end
      5: begin r = a | b; wnz = 1; end
      6: begin r = a ^ b; wnz = 1; end
      7: begin r = 8'hFF - a; cc = 1; wnz = 1; wc = 1; end
      8: begin
        t = 0 - int'(a); r = t[7:0]; cc = (a != 0); hh = (a[3:0] != 0);
        vv = (a == 8'h80); wnz = 1; wc = 1; wh = 1;
      end
      9:  begin r = a + 8'd1; vv = (r == 8'h80); wnz = 1; end
      10: begin r = a - 8'd1; vv = (r == 8'h7F); wnz = 1; end
      11: begin r = {a[6:0], 1'b0}; cc = a[7]; vv = r[7] ^ cc; wnz = 1; wc = 1; end
      12: begin r = {1'b0, a[7:1]}; cc = a[0]; vv = r[7] ^ cc; wnz = 1; wc = 1; end
      13: begin r = {a[6:0], s[0]}; cc = a[7]; vv = r[7] ^ cc; wnz = 1; wc = 1; end
      14: begin r = {s[0], a[7:1]}; cc = a[0]; vv = r[7] ^ cc; wnz = 1; wc = 1; end
      15: begin r = {a[7], a[7:1]}; cc = a[0]; vv = r[7] ^ cc; wnz = 1; wc = 1; end
      16: r = {a[3:0], a[7:4]};
      17: n[b[2:0]] = 1'b1;
      18: n[b[2:0]] = 1'b0;
      default: ;
    endcase
    if (wnz) begin
      n[2] = r[7]; n[1] = (r == 8'h00); n[3] = vv; n[4] = n[2] ^ n[3];
    end
    if (wc) n[0] = cc;
    if (wh) n[5] = hh;
    return {r, n};
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic we);
    logic [15:0] e;
    @(negedge clk);
    op = o; opa = a; opb = b; flag_we = we;
    #1;
    e = model(o, a, b, m_sreg);
    check("R2", "sreg", sreg, m_sreg);
    check(req_of(o), "res", res, e[15:8]);
    check(req_of(o), "sreg_next", sreg_next, e[7:0]);
    @(posedge clk);
    if (we) m_sreg = e[7:0];
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst = 1'b1; op = 5'd17; opa = 8'h00; opb = 8'h07; flag_we = 1'b1;
    m_sreg = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset wins over a simultaneous flag write
    check("R1", "sreg under reset", sreg, 8'h00);
    rst = 1'b0; flag_we = 1'b0;

    // R11: set I and T, clear them later
    apply(5'd17, 8'h3C, 8'h07, 1);
    apply(5'd17, 8'h00, 8'h06, 1);
    apply(5'd18, 8'h00, 8'h07, 1);
    // R2: strobe low keeps the register
    apply(5'd17, 8'h00, 8'h00, 0);
    apply(5'd4, 8'h00, 8'h00, 0);
    // R3 corners
    apply(5'd0, 8'h7F, 8'h01, 1);
    apply(5'd0, 8'hFF, 8'h01, 1);
    apply(5'd1, 8'h0F, 8'h00, 1);
    apply(5'd0, 8'h80, 8'h80, 1);
    // R4 corners
    apply(5'd2, 8'h80, 8'h01, 1);
    apply(5'd2, 8'h00, 8'h01, 1);
    apply(5'd3, 8'h10, 8'h0F, 1);
    apply(5'd3, 8'h05, 8'h05, 1);
    // R8 corners
    apply(5'd8, 8'h80, 8'h00, 1);
    apply(5'd8, 8'h00, 8'h00, 1);
    apply(5'd8, 8'h10, 8'h00, 1);
    // R6 corners
    apply(5'd9, 8'h7F, 8'h00, 1);
    apply(5'd10, 8'h80, 8'h00, 1);
    apply(5'd9, 8'hFF, 8'h00, 1);
    // R7
    apply(5'd7, 8'hFF, 8'h00, 1);
    // R5
    apply(5'd4, 8'hF0, 8'h0F, 1);
    apply(5'd6, 8'hAA, 8'h55, 1);
    // R9 with carry set and clear
    apply(5'd17, 8'h00, 8'h00, 1);
    apply(5'd13, 8'h80, 8'h00, 1);
    apply(5'd14, 8'h01, 8'h00, 1);
    apply(5'd15, 8'h81, 8'h00, 1);
    apply(5'd11, 8'h40, 8'h00, 1);
    apply(5'd12, 8'h01, 8'h00, 1);
    // R10
    apply(5'd16, 8'hA5, 8'h00, 1);

    // Constrained random, mostly committing so carry chains
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] ro;
      ro = 5'($urandom % 19);
      apply(ro, 8'($urandom), 8'($urandom), ($urandom % 4) != 0);
    end

    // R1 again after activity
    @(negedge clk);
    rst = 1'b1; op = 5'd17; opb = 8'h00; flag_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "sreg after reset", sreg, 8'h00);
    rst = 1'b0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

endmodule